// File: doc/BRIEF.md
# Outstanding Read Merge Table

This block sits between a group of requesters and a split-transaction memory bus and keeps one record for each line read that is in flight. A requester presents a line address on a shared request channel, tagged with its own index. If no unanswered read to that line exists, the block claims a free record and sends a single memory request. The request carries the record's index as its tag. If a read to the same line is already waiting for memory, the newcomer is only marked as a sharer in that record, and no extra memory traffic is created. A requester is never blocked by its own pending reads. It may present further reads while earlier ones wait.

Memory answers later on a response channel that names the tag. The block latches the returned line in the record. It then hands the line to each marked requester in turn, over that requester's own valid/ready pair, and it keeps the data for as long as a requester is not ready. Every delivery carries a flag that tells the requester whether to install the line as shared or exclusive. A record returns to the free pool at the moment its last sharer takes the data.

Top module: `rd_merge_table`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and dlv_valid is all zeros.
- R2: A request accepted with no matching record claims the lowest-numbered free record. In the next cycle mem_req_valid is 1 for exactly one cycle, with mem_req_addr equal to the request address and mem_req_tag equal to that record's index.
- R3: A request whose address equals that of a record still waiting for memory is accepted without any memory request and marks the requester in that record. The same requester may meanwhile issue reads to other lines, and those are served independently.
- R4: With every record occupied, a request that matches no waiting record sees req_ready at 0 until a record frees. A request that matches a waiting record is still accepted while the table is full.
- R5: One memory response is delivered to every marked requester, one requester at a time in ascending requester index. At most one bit of dlv_valid is 1, and delivery moves on only after dlv_ready is seen high for the requester being served.
- R6: While the served requester holds dlv_ready low, dlv_valid, dlv_addr, dlv_data and dlv_shared keep their values, so the data is never lost.
- R7: dlv_shared is 1 for every delivery of a line that had two or more distinct requesters marked, and 0 when a single requester asked for it.
- R8: A record is released in the cycle its last delivery handshake completes. A later read to the same address then claims a fresh record and sends a new memory request.
- R9: A matching request accepted in the same cycle as the response for that record is added to the record, receives the data, and the line is reported shared.
- R10: A request to an address whose data has already arrived but not yet been fully delivered does not merge. It claims a new record and sends its own memory request.
- R11: When several records hold returned data, they are served in ascending record index, each finished before the next begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_id | input | ID_W | Index of the requesting agent |
| req_addr | input | ADDR_W | Line address to read |
| mem_req_valid | output | 1 | Memory read request, one-cycle pulse |
| mem_req_addr | output | ADDR_W | Address sent to memory |
| mem_req_tag | output | ENT_W | Record index used as transaction tag |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | ENT_W | Tag of the answered request |
| rsp_data | input | DATA_W | Returned line data |
| dlv_valid | output | NUM_REQ | Per-requester data valid |
| dlv_ready | input | NUM_REQ | Per-requester data accept |
| dlv_addr | output | ADDR_W | Address of the delivered line |
| dlv_data | output | DATA_W | Delivered line data |
| dlv_shared | output | 1 | Install as shared (1) or exclusive (0) |

## Verification
The properties assume a well-behaved memory side: every response names a tag that was sent out and is still waiting, each tag is answered once, and no answer comes before its memory request has been seen. They also assume a requester keeps req_id and req_addr steady while req_valid waits for req_ready. The stimulus keeps to this by answering only tags the bench itself predicted from the allocation order and by holding request fields until acceptance. Merges, back-pressure on delivery and full-table stalls are provoked on purpose.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int RMT_REQS    = 4;
  localparam int RMT_ENTRIES = 8;
  localparam int RMT_ADDR_W  = 32;
  localparam int RMT_DATA_W  = 32;

  typedef enum logic {
    DL_IDLE = 1'b0,
    DL_BUSY = 1'b1
  } dl_state_e;
endpackage

// File: rtl/rmt_pick.sv
module rmt_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/rmt_entry.sv
module rmt_entry #(
  parameter int NUM_REQ = rmt_pkg::RMT_REQS,
  parameter int ADDR_W  = rmt_pkg::RMT_ADDR_W,
  parameter int DATA_W  = rmt_pkg::RMT_DATA_W,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  input  logic               merge_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               fill_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  input  logic               done_i,
  input  logic [ID_W-1:0]    dlv_id_i,
  output logic               valid_o,
  output logic               filled_o,
  output logic               merged_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [NUM_REQ-1:0] mask_o,
  output logic [DATA_W-1:0]  data_o
);
  logic               valid_q, valid_d;
  logic               filled_q, filled_d;
  logic               merged_q, merged_d;
  logic [NUM_REQ-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [NUM_REQ-1:0] req_bit, dlv_bit;
  logic               addr_en, data_en;

  assign req_bit = NUM_REQ'(1) << id_i;
  assign dlv_bit = NUM_REQ'(1) << dlv_id_i;
  assign addr_en = alloc_i;
  assign data_en = fill_i & valid_q;

  always_comb begin
    valid_d  = valid_q;
    filled_d = filled_q;
    merged_d = merged_q;
    mask_d   = mask_q;
    if (alloc_i) begin
      valid_d  = 1'b1;
      filled_d = 1'b0;
      merged_d = 1'b0;
      mask_d   = req_bit;
    end
    if (merge_i) begin
      if ((mask_q & req_bit) == '0) merged_d = 1'b1;
      mask_d = mask_d | req_bit;
    end
    if (data_en) filled_d = 1'b1;
    if (done_i) begin
      mask_d = mask_d & ~dlv_bit;
      if (mask_d == '0) begin
        valid_d  = 1'b0;
        filled_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      filled_q <= 1'b0;
      merged_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      valid_q  <= valid_d;
      filled_q <= filled_d;
      merged_q <= merged_d;
      mask_q   <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_i;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= fill_data_i;
  end

  assign valid_o  = valid_q;
  assign filled_o = filled_q;
  assign merged_o = merged_q;
  assign addr_o   = addr_q;
  assign mask_o   = mask_q;
  assign data_o   = data_q;
endmodule

// File: rtl/rd_merge_table.sv
module rd_merge_table #(
  parameter int NUM_REQ = rmt_pkg::RMT_REQS,
  parameter int NUM_ENT = rmt_pkg::RMT_ENTRIES,
  parameter int ADDR_W  = rmt_pkg::RMT_ADDR_W,
  parameter int DATA_W  = rmt_pkg::RMT_DATA_W,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int ENT_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ID_W-1:0]    req_id,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ENT_W-1:0]   mem_req_tag,
  input  logic               rsp_valid,
  input  logic [ENT_W-1:0]   rsp_tag,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic [NUM_REQ-1:0] dlv_valid,
  input  logic [NUM_REQ-1:0] dlv_ready,
  output logic [ADDR_W-1:0]  dlv_addr,
  output logic [DATA_W-1:0]  dlv_data,
  output logic               dlv_shared
);
  import rmt_pkg::*;

  // per-record state views
  logic [NUM_ENT-1:0] ent_valid, ent_filled, ent_merged;
  logic [ADDR_W-1:0]  ent_addr [NUM_ENT];
  logic [DATA_W-1:0]  ent_data [NUM_ENT];
  logic [NUM_REQ-1:0] ent_mask [NUM_ENT];

  // per-record strobes
  logic [NUM_ENT-1:0] match_vec, free_vec, ready_vec;
  logic [NUM_ENT-1:0] alloc_vec, merge_vec, fill_vec, done_vec;

  logic             hit, has_free, any_ready;
  logic [ENT_W-1:0] hit_idx, free_idx, rdy_idx;
  logic             accept, issue;

  // delivery engine
  dl_state_e          dl_state_q, dl_state_d;
  logic [ENT_W-1:0]   dl_ent_q, dl_ent_d;
  logic               dl_ent_en;
  logic [NUM_REQ-1:0] cur_mask;
  logic               cur_found;
  logic [ID_W-1:0]    cur_id;
  logic [NUM_REQ-1:0] cur_bit;
  logic               dlv_fire, dlv_last;

  // outgoing memory request registers
  logic               mreq_v_q;
  logic [ADDR_W-1:0]  mreq_addr_q;
  logic [ENT_W-1:0]   mreq_tag_q;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign match_vec[e] = ent_valid[e] & ~ent_filled[e] & (ent_addr[e] == req_addr);
    assign free_vec[e]  = ~ent_valid[e];
    assign ready_vec[e] = ent_valid[e] & ent_filled[e];
    assign alloc_vec[e] = issue & (free_idx == ENT_W'(e));
    assign merge_vec[e] = accept & hit & (hit_idx == ENT_W'(e));
    assign fill_vec[e]  = rsp_valid & (rsp_tag == ENT_W'(e));
    assign done_vec[e]  = dlv_fire & (dl_ent_q == ENT_W'(e));

    rmt_entry #(
      .NUM_REQ(NUM_REQ),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_vec[e]),
      .merge_i    (merge_vec[e]),
      .id_i       (req_id),
      .addr_i     (req_addr),
      .fill_i     (fill_vec[e]),
      .fill_data_i(rsp_data),
      .done_i     (done_vec[e]),
      .dlv_id_i   (cur_id),
      .valid_o    (ent_valid[e]),
      .filled_o   (ent_filled[e]),
      .merged_o   (ent_merged[e]),
      .addr_o     (ent_addr[e]),
      .mask_o     (ent_mask[e]),
      .data_o     (ent_data[e])
    );
  end

  rmt_pick #(.N(NUM_ENT)) u_pick_hit  (.vec(match_vec), .found(hit),       .idx(hit_idx));
  rmt_pick #(.N(NUM_ENT)) u_pick_free (.vec(free_vec),  .found(has_free),  .idx(free_idx));
  rmt_pick #(.N(NUM_ENT)) u_pick_rdy  (.vec(ready_vec), .found(any_ready), .idx(rdy_idx));

  assign req_ready = hit | has_free;
  assign accept    = req_valid & req_ready;
  assign issue     = accept & ~hit;

  // memory request path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreq_v_q <= 1'b0;
    else        mreq_v_q <= issue;
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      mreq_addr_q <= req_addr;
      mreq_tag_q  <= free_idx;
    end
  end

  assign mem_req_valid = mreq_v_q;
  assign mem_req_addr  = mreq_addr_q;
  assign mem_req_tag   = mreq_tag_q;

  // delivery: one record at a time, one requester at a time
  assign cur_mask = ent_mask[dl_ent_q];

  rmt_pick #(.N(NUM_REQ)) u_pick_req (.vec(cur_mask), .found(cur_found), .idx(cur_id));

  assign cur_bit  = NUM_REQ'(1) << cur_id;
  assign dlv_fire = (dl_state_q == DL_BUSY) & cur_found & dlv_ready[cur_id];
  assign dlv_last = (cur_mask & ~cur_bit) == '0;

  always_comb begin
    dl_state_d = dl_state_q;
    dl_ent_d   = dl_ent_q;
    dl_ent_en  = 1'b0;
    unique case (dl_state_q)
      DL_IDLE: begin
        if (any_ready) begin
          dl_state_d = DL_BUSY;
          dl_ent_d   = rdy_idx;
          dl_ent_en  = 1'b1;
        end
      end
      DL_BUSY: begin
        if (dlv_fire && dlv_last) dl_state_d = DL_IDLE;
      end
      default: dl_state_d = DL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_state_q <= DL_IDLE;
      dl_ent_q   <= '0;
    end else begin
      dl_state_q <= dl_state_d;
      if (dl_ent_en) dl_ent_q <= dl_ent_d;
    end
  end

  assign dlv_valid  = ((dl_state_q == DL_BUSY) && cur_found) ? cur_bit : '0;
  assign dlv_addr   = ent_addr[dl_ent_q];
  assign dlv_data   = ent_data[dl_ent_q];
  assign dlv_shared = ent_merged[dl_ent_q];
endmodule

// File: rtl/rmt_chk.sv
module rmt_chk #(
  parameter int NUM_REQ = 4,
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic [NUM_REQ-1:0] dlv_valid,
  input logic [NUM_REQ-1:0] dlv_ready,
  input logic [ADDR_W-1:0]  dlv_addr,
  input logic [DATA_W-1:0]  dlv_data,
  input logic               dlv_shared,
  input logic [NUM_ENT-1:0] ent_valid
);
  // R5: never more than one requester offered data at once
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_valid));

  // R6: an unaccepted delivery stays put
  a_r6_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dlv_valid & ~dlv_ready)) |=>
      (dlv_valid == $past(dlv_valid)) && $stable(dlv_addr) &&
      $stable(dlv_data) && $stable(dlv_shared));

  // R4: a stall only happens with every record occupied
  a_r4_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (&ent_valid));

  // R2: a memory request follows an accepted request
  a_r2_mem_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $past(req_valid && req_ready));

  // R2: the memory request is a single-cycle pulse per accepted miss
  a_r2_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && $past(mem_req_valid)) |-> $past(req_valid && req_ready, 2));
endmodule

bind rd_merge_table rmt_chk #(
  .NUM_REQ(NUM_REQ),
  .NUM_ENT(NUM_ENT),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/sim_rd_merge_table.sv
module sim_rd_merge_table;
  localparam int NR = 4;
  localparam int NE = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_id;
  logic [AW-1:0] req_addr;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [2:0]    mem_req_tag;
  logic          rsp_valid;
  logic [2:0]    rsp_tag;
  logic [DW-1:0] rsp_data;
  logic [NR-1:0] dlv_valid;
  logic [NR-1:0] dlv_ready;
  logic [AW-1:0] dlv_addr;
  logic [DW-1:0] dlv_data;
  logic          dlv_shared;

  rd_merge_table #(.NUM_REQ(NR), .NUM_ENT(NE), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_addr(dlv_addr),
    .dlv_data(dlv_data), .dlv_shared(dlv_shared)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int unsigned   who;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit            shr;
    string         rq;
  } dexp_t;

  typedef struct {
    logic [AW-1:0] addr;
    int unsigned   tag;
    string         rq;
  } mexp_t;

  dexp_t dq[$];
  mexp_t mq[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) begin
        if (mq.size() == 0) begin
          chk(1'b0, "R3", "unexpected memory request addr", 64'(mem_req_addr), 64'hx);
        end else begin
          mexp_t m;
          m = mq.pop_front();
          chk(mem_req_addr == m.addr, m.rq, "memory request address", 64'(mem_req_addr), 64'(m.addr));
          chk(32'(mem_req_tag) == m.tag, m.rq, "memory request tag", 64'(mem_req_tag), 64'(m.tag));
        end
      end
      for (int i = 0; i < NR; i++) begin
        if (dlv_valid[i] && dlv_ready[i]) begin
          if (dq.size() == 0) begin
            chk(1'b0, "R5", "unexpected delivery to requester", 64'(i), 64'hx);
          end else begin
            dexp_t d;
            d = dq.pop_front();
            chk(i == int'(d.who), d.rq, "delivery requester", 64'(i), 64'(d.who));
            chk(dlv_addr == d.addr, d.rq, "delivery address", 64'(dlv_addr), 64'(d.addr));
            chk(dlv_data == d.data, d.rq, "delivery data", 64'(dlv_data), 64'(d.data));
            chk(dlv_shared == d.shr, d.rq, "delivery shared flag", 64'(dlv_shared), 64'(d.shr));
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input int id, input logic [AW-1:0] addr, input bit alloc,
                       input int tag, input string rq);
    if (alloc) mq.push_back('{addr: addr, tag: tag, rq: rq});
    req_valid = 1'b1;
    req_id    = 2'(id);
    req_addr  = addr;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic respond(input int tag, input logic [DW-1:0] data);
    rsp_valid = 1'b1;
    rsp_tag   = 3'(tag);
    rsp_data  = data;
    @(posedge clk);
    #1 rsp_valid = 1'b0;
  endtask

  task automatic expect_dlv(input int who, input logic [AW-1:0] addr,
                            input logic [DW-1:0] data, input bit shr, input string rq);
    dq.push_back('{who: who, addr: addr, data: data, shr: shr, rq: rq});
  endtask

  task automatic drain(input string rq);
    int n = 0;
    while ((dq.size() != 0 || mq.size() != 0) && n < 2000) begin
      @(posedge clk);
      n++;
    end
    #1;
    chk(dq.size() == 0, rq, "pending deliveries after drain", 64'(dq.size()), 64'd0);
    chk(mq.size() == 0, rq, "pending memory requests after drain", 64'(mq.size()), 64'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_id    = '0;
    req_addr  = '0;
    rsp_valid = 1'b0;
    rsp_tag   = '0;
    rsp_data  = '0;
    dlv_ready = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: idle state after reset
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk(dlv_valid == '0, "R1", "dlv_valid after reset", 64'(dlv_valid), 64'd0);
    @(posedge clk); #1;

    // R2 / R7: plain misses, single requester per line, exclusive fills
    dlv_ready = '1;
    issue(0, 32'h100, 1'b1, 0, "R2");
    issue(1, 32'h200, 1'b1, 1, "R2");
    expect_dlv(0, 32'h100, 32'hA0, 1'b0, "R7");
    respond(0, 32'hA0);
    expect_dlv(1, 32'h200, 32'hB0, 1'b0, "R7");
    respond(1, 32'hB0);
    drain("R2");

    // R3 / R5 / R6: merges, ordered fan-out, held data
    dlv_ready = '0;
    issue(0, 32'h300, 1'b1, 0, "R2");
    issue(2, 32'h300, 1'b0, 0, "R3");
    issue(2, 32'h340, 1'b1, 1, "R3");
    issue(3, 32'h300, 1'b0, 0, "R3");
    tick(3);
    expect_dlv(0, 32'h300, 32'hC1, 1'b1, "R5");
    expect_dlv(2, 32'h300, 32'hC1, 1'b1, "R5");
    expect_dlv(3, 32'h300, 32'hC1, 1'b1, "R7");
    respond(0, 32'hC1);
    tick(4);
    @(negedge clk);
    chk(dlv_valid == 4'b0001, "R6", "held dlv_valid", 64'(dlv_valid), 64'h1);
    chk(dlv_data == 32'hC1, "R6", "held dlv_data", 64'(dlv_data), 64'hC1);
    chk(dlv_shared == 1'b1, "R7", "held dlv_shared", 64'(dlv_shared), 64'd1);
    @(posedge clk); #1;
    dlv_ready = 4'b1000;
    tick(3);
    @(negedge clk);
    chk(dlv_valid == 4'b0001, "R5", "lowest requester still served first", 64'(dlv_valid), 64'h1);
    @(posedge clk); #1;
    dlv_ready = '1;
    drain("R5");
    expect_dlv(2, 32'h340, 32'hC2, 1'b0, "R3");
    respond(1, 32'hC2);
    drain("R3");

    // R4 / R11 / R8: full table, merge while full, ordered records, reuse
    dlv_ready = '0;
    for (int k = 0; k < NE; k++) issue(0, 32'h1000 + 32'(k * 64), 1'b1, k, "R4");
    req_valid = 1'b1;
    req_id    = 2'd1;
    req_addr  = 32'h5000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R4", "stall with full table", 64'(req_ready), 64'd0);
    end
    @(posedge clk); #1;
    req_addr = 32'h1000 + 32'(3 * 64);
    @(negedge clk);
    chk(req_ready == 1'b1, "R4", "merge accepted while full", 64'(req_ready), 64'd1);
    @(posedge clk); #1 req_valid = 1'b0;
    for (int k = 0; k < NE; k++) begin
      expect_dlv(0, 32'h1000 + 32'(k * 64), 32'hD0 + 32'(k), (k == 3), "R11");
      if (k == 3) expect_dlv(1, 32'h1000 + 32'(k * 64), 32'hD0 + 32'(k), 1'b1, "R7");
    end
    for (int k = 0; k < NE; k++) respond(k, 32'hD0 + 32'(k));
    tick(2);
    dlv_ready = '1;
    drain("R11");
    issue(2, 32'h1000, 1'b1, 0, "R8");
    expect_dlv(2, 32'h1000, 32'hE0, 1'b0, "R8");
    respond(0, 32'hE0);
    drain("R8");

    // R9 / R10: merge in the response cycle, no merge after data arrived
    dlv_ready = '0;
    issue(0, 32'h7000, 1'b1, 0, "R9");
    expect_dlv(0, 32'h7000, 32'hF0, 1'b1, "R9");
    expect_dlv(1, 32'h7000, 32'hF0, 1'b1, "R9");
    req_valid = 1'b1;
    req_id    = 2'd1;
    req_addr  = 32'h7000;
    rsp_valid = 1'b1;
    rsp_tag   = 3'd0;
    rsp_data  = 32'hF0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "merge accepted in response cycle", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    rsp_valid = 1'b0;
    tick(2);
    issue(2, 32'h7000, 1'b1, 1, "R10");
    expect_dlv(2, 32'h7000, 32'hF1, 1'b0, "R10");
    respond(1, 32'hF1);
    tick(2);
    dlv_ready = '1;
    drain("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule